// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a serial chain of boundary-scan cells that sits between the core logic and the device pins. It has one cell for each observed input pin, one cell for each driven output pin, and one output-enable cell for each group of output pins. Each cell holds a capture/shift stage that is clocked on the rising edge of the test clock. It also holds a separate update latch that is clocked on the falling edge. The chain runs from `tdi_i` through every cell to `so_o`. A test access port controller outside the block supplies the capture, shift, update, select and reset strobes, plus a level that says the extest instruction is current.

During sample/preload the pins keep following the core. A single shift pass carries out the captured snapshot while new preload data goes into the chain. An update then parks the preload data in the latches. A small mode state machine has two states, `MODE_FUNC` and `MODE_EXTEST`. The transition FUNC→EXTEST is taken on the rising edge at which `extest_i` is high and `tlr_i` is low. The transition EXTEST→FUNC is taken on the rising edge at which `extest_i` is low or `tlr_i` is high, and at once when `trst_ni` goes low. In `MODE_EXTEST` the pins are driven from the update latches with no further scan pass.

Top module: `bsr_chain`

## Requirements
- R1: The chain has NUM_IN + NUM_GRP*(GRP_W+1) cells (16 by default). Cell 0 takes `tdi_i`. Cells 0..NUM_IN-1 observe `pin_in_i` bits 0..NUM_IN-1. After those, each group g in ascending order has its enable cell first, followed by the cells for data bits g*GRP_W..g*GRP_W+GRP_W-1 in ascending order. The last cell drives `so_o`.
- R2: On a rising edge with `sel_i` and `capture_dr_i` high, every stage loads its parallel value. An input cell loads its pin, a data cell loads `core_out_i`, and an enable cell loads `core_oe_i`.
- R3: On a rising edge with `sel_i` and `shift_dr_i` high and `capture_dr_i` low, every stage takes the value of its neighbour nearer TDI, and cell 0 takes `tdi_i`. Capture wins when both capture and shift are high.
- R4: On a falling edge with `sel_i` and `update_dr_i` high, each update latch copies its stage. At all other times the latches hold their contents, including across mode changes and test-logic-reset.
- R5: In `MODE_FUNC`, `pin_out_o` equals `core_out_i` and `pin_oe_o` equals `core_oe_i` combinationally, whatever the capture, shift and update strobes do.
- R6: FUNC→EXTEST happens on the first rising edge at which `extest_i`=1 and `tlr_i`=0. From then on, `pin_out_o` and `pin_oe_o` show the data latches and the group enable latches (1 = driver enabled), and changes in the core have no effect on them.
- R7: EXTEST→FUNC happens on a rising edge at which `extest_i`=0 or `tlr_i`=1. `trst_ni`=0 forces FUNC at once, without a clock edge, and clears every stage to 0.
- R8: While `sel_i`=0, the capture, shift and update strobes have no effect on the stages or on the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| trst_ni | input | 1 | Asynchronous test reset, active low |
| tlr_i | input | 1 | Controller is in test-logic-reset |
| sel_i | input | 1 | Chain is the selected data register |
| capture_dr_i | input | 1 | Capture strobe |
| shift_dr_i | input | 1 | Shift strobe |
| update_dr_i | input | 1 | Update strobe (acts on falling edge) |
| extest_i | input | 1 | Extest instruction is current |
| tdi_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out (last cell) |
| pin_in_i | input | NUM_IN | Input pin values |
| core_out_i | input | NUM_GRP*GRP_W | Core output data |
| core_oe_i | input | NUM_GRP | Core output enables, one per group |
| pin_out_o | output | NUM_GRP*GRP_W | Data to output pins |
| pin_oe_o | output | NUM_GRP | Output pin enables, one per group |

## Verification
A wrong mode state shows up on the pins in the same cycle. They either keep following a core that is meant to be masked, or they show latch data during sample/preload. A corrupted stage or a broken cell order shows up at `so_o` within one capture and 16 shift edges. A latch that loads when it should not, or that fails to load, stays hidden until extest is entered. It is then exposed on the first rising edge of extest, so each sweep step enters extest directly after its update.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    typedef enum logic {
        MODE_FUNC   = 1'b0,
        MODE_EXTEST = 1'b1
    } bsr_mode_e;

    typedef enum logic [1:0] {
        CELL_IN   = 2'd0,
        CELL_OE   = 2'd1,
        CELL_DATA = 2'd2
    } cell_kind_e;

    // Kind of the cell at chain position idx.
    function automatic cell_kind_e kind_of(int idx, int n_in, int grp_w);
        if (idx < n_in)
            return CELL_IN;
        else if (((idx - n_in) % (grp_w + 1)) == 0)
            return CELL_OE;
        else
            return CELL_DATA;
    endfunction

    // Output group that an output-side cell belongs to.
    function automatic int group_of(int idx, int n_in, int grp_w);
        if (idx < n_in)
            return 0;
        return (idx - n_in) / (grp_w + 1);
    endfunction

    // Data bit within its group of a data cell.
    function automatic int bit_of(int idx, int n_in, int grp_w);
        int rel;
        if (idx < n_in)
            return 0;
        rel = (idx - n_in) % (grp_w + 1);
        return (rel == 0) ? 0 : rel - 1;
    endfunction

endpackage

// File: rtl/bsr_cell.sv
`timescale 1ns/1ps
module bsr_cell (
    input  logic tck_i,
    input  logic trst_ni,
    input  logic sel_i,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic si_i,
    input  logic par_i,
    output logic so_o,
    output logic lq_o
);

    logic sh_q;
    logic lat_q;
    logic armed_q;

    // Capture/shift stage, rising edge.
    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni) begin
            sh_q <= 1'b0;
        end else if (sel_i) begin
            if (capture_i)
                sh_q <= par_i;
            else if (shift_i)
                sh_q <= si_i;
        end
    end

    // Update latch, falling edge; contents undefined after reset.
    always_ff @(negedge tck_i) begin
        if (sel_i && update_i)
            lat_q <= sh_q;
    end

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni)
            armed_q <= 1'b0;
        else
            armed_q <= 1'b1;
    end

    assign so_o = sh_q;
    assign lq_o = lat_q;

    p_capture_r2: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (sel_i && capture_i) |=> (so_o == $past(par_i)));

    p_shift_r3: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (sel_i && shift_i && !capture_i) |=> (so_o == $past(si_i)));

    p_idle_hold_r8: assert property (@(posedge tck_i) disable iff (!trst_ni)
        !sel_i |=> $stable(so_o));

    p_latch_hold_r4: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (armed_q && !(sel_i && update_i)) |-> $stable(lq_o));

endmodule

// File: rtl/bsr_mode_fsm.sv
`timescale 1ns/1ps
module bsr_mode_fsm
    import bsr_pkg::*;
(
    input  logic      tck_i,
    input  logic      trst_ni,
    input  logic      tlr_i,
    input  logic      extest_i,
    output bsr_mode_e mode_o
);

    bsr_mode_e state_q;
    bsr_mode_e state_d;

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni)
            state_q <= MODE_FUNC;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FUNC: begin
                if (extest_i && !tlr_i)
                    state_d = MODE_EXTEST;
            end
            MODE_EXTEST: begin
                if (!extest_i || tlr_i)
                    state_d = MODE_FUNC;
            end
        endcase
    end

    assign mode_o = state_q;

    p_enter_extest_r6: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (extest_i && !tlr_i) |=> (mode_o == MODE_EXTEST));

    p_leave_extest_r7: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (!extest_i || tlr_i) |=> (mode_o == MODE_FUNC));

endmodule

// File: rtl/bsr_chain.sv
`timescale 1ns/1ps
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_GRP = 2,
    parameter int GRP_W   = 5
) (
    input  logic                       tck_i,
    input  logic                       trst_ni,
    input  logic                       tlr_i,
    input  logic                       sel_i,
    input  logic                       capture_dr_i,
    input  logic                       shift_dr_i,
    input  logic                       update_dr_i,
    input  logic                       extest_i,
    input  logic                       tdi_i,
    output logic                       so_o,
    input  logic [NUM_IN-1:0]          pin_in_i,
    input  logic [NUM_GRP*GRP_W-1:0]   core_out_i,
    input  logic [NUM_GRP-1:0]         core_oe_i,
    output logic [NUM_GRP*GRP_W-1:0]   pin_out_o,
    output logic [NUM_GRP-1:0]         pin_oe_o
);

    localparam int NUM_OUT   = NUM_GRP * GRP_W;
    localparam int CELL_GRP  = GRP_W + 1;
    localparam int CHAIN_LEN = NUM_IN + NUM_GRP * CELL_GRP;

    logic [CHAIN_LEN-1:0] sh;
    logic [CHAIN_LEN-1:0] lq;
    logic [CHAIN_LEN-1:0] par;
    logic [CHAIN_LEN-1:0] si_vec;
    logic [NUM_OUT-1:0]   lat_dat;
    logic [NUM_GRP-1:0]   lat_oe;
    bsr_mode_e            mode;
    logic                 armed_q;

    assign si_vec = {sh[CHAIN_LEN-2:0], tdi_i};

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
        localparam cell_kind_e KIND = kind_of(k, NUM_IN, GRP_W);
        localparam int         GRP  = group_of(k, NUM_IN, GRP_W);
        localparam int         BIT  = bit_of(k, NUM_IN, GRP_W);

        if (KIND == CELL_IN) begin : g_in
            assign par[k] = pin_in_i[k];
        end else if (KIND == CELL_OE) begin : g_oe
            assign par[k] = core_oe_i[GRP];
        end else begin : g_dat
            assign par[k] = core_out_i[GRP*GRP_W + BIT];
        end

        bsr_cell u_cell (
            .tck_i     (tck_i),
            .trst_ni   (trst_ni),
            .sel_i     (sel_i),
            .capture_i (capture_dr_i),
            .shift_i   (shift_dr_i),
            .update_i  (update_dr_i),
            .si_i      (si_vec[k]),
            .par_i     (par[k]),
            .so_o      (sh[k]),
            .lq_o      (lq[k])
        );
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int BASE = NUM_IN + g * CELL_GRP;
        assign lat_oe[g] = lq[BASE];
        for (genvar b = 0; b < GRP_W; b++) begin : g_bit
            assign lat_dat[g*GRP_W + b] = lq[BASE + 1 + b];
        end
    end

    bsr_mode_fsm u_mode (
        .tck_i    (tck_i),
        .trst_ni  (trst_ni),
        .tlr_i    (tlr_i),
        .extest_i (extest_i),
        .mode_o   (mode)
    );

    // Output process: pin drive selected by mode state.
    always_comb begin
        unique case (mode)
            MODE_FUNC: begin
                pin_out_o = core_out_i;
                pin_oe_o  = core_oe_i;
            end
            MODE_EXTEST: begin
                pin_out_o = lat_dat;
                pin_oe_o  = lat_oe;
            end
        endcase
    end

    assign so_o = sh[CHAIN_LEN-1];

    always_ff @(posedge tck_i or negedge trst_ni) begin
        if (!trst_ni)
            armed_q <= 1'b0;
        else
            armed_q <= 1'b1;
    end

    p_func_follow_r5: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (armed_q && $past(!extest_i || tlr_i)) |->
            (pin_out_o == core_out_i && pin_oe_o == core_oe_i));

    p_extest_hold_r6: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (armed_q && $past(mode == MODE_EXTEST) && mode == MODE_EXTEST
         && !(sel_i && update_dr_i)) |->
            ($stable(pin_out_o) && $stable(pin_oe_o)));

    p_reset_func_r7: assert property (@(posedge tck_i)
        !trst_ni |-> (pin_out_o == core_out_i && so_o == 1'b0));

endmodule

// File: tb/bsr_chain_tb_top.sv
`timescale 1ns/1ps
module bsr_chain_tb_top;

    logic        tck = 1'b0;
    logic        trst_n, tlr, sel, cap, shf, upd, extest, tdi;
    logic        so;
    logic [3:0]  pin_in;
    logic [9:0]  core_out;
    logic [1:0]  core_oe;
    logic [9:0]  pin_out;
    logic [1:0]  pin_oe;

    int tests = 0;
    int fails = 0;

    always #4 tck = ~tck;

    bsr_chain dut_i (
        .tck_i(tck), .trst_ni(trst_n), .tlr_i(tlr), .sel_i(sel),
        .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd),
        .extest_i(extest), .tdi_i(tdi), .so_o(so),
        .pin_in_i(pin_in), .core_out_i(core_out), .core_oe_i(core_oe),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #2;
    endtask

    // Parallel value of cell k per the R1 ordering.
    function automatic logic cell_par(int k, logic [3:0] p, logic [9:0] co, logic [1:0] oe);
        int rel, g;
        if (k < 4) return p[k];
        rel = (k - 4) % 6;
        g   = (k - 4) / 6;
        if (rel == 0) return oe[g];
        return co[g*5 + rel - 1];
    endfunction

    function automatic logic [15:0] cap_vec(logic [3:0] p, logic [9:0] co, logic [1:0] oe);
        logic [15:0] v;
        for (int k = 0; k < 16; k++) v[k] = cell_par(k, p, co, oe);
        return v;
    endfunction

    // Expected {oe, data} in extest for chain contents pre (cell k = pre[k]).
    function automatic logic [11:0] ext_vec(logic [15:0] pre);
        logic [11:0] v;
        for (int g = 0; g < 2; g++) begin
            v[10+g] = pre[4 + g*6];
            for (int b = 0; b < 5; b++) v[g*5+b] = pre[4 + g*6 + 1 + b];
        end
        return v;
    endfunction

    // Capture, 16 shifts feeding pre, then update.
    task automatic scan(input logic [15:0] pre, output logic [15:0] seen, output int func_bad);
        func_bad = 0;
        sel = 1'b1; cap = 1'b1; step();
        cap = 1'b0; shf = 1'b1;
        for (int j = 0; j < 16; j++) begin
            seen[15-j] = so;
            tdi = pre[15-j];
            if (extest == 1'b0 && (pin_out !== core_out || pin_oe !== core_oe)) func_bad++;
            step();
        end
        shf = 1'b0; upd = 1'b1; step();
        upd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] pre, seen, last_pre;
        logic [15:0] cv;
        int bad;
        trst_n = 1'b0; tlr = 1'b0; sel = 1'b0; cap = 1'b0; shf = 1'b0;
        upd = 1'b0; extest = 1'b0; tdi = 1'b0;
        pin_in = 4'h9; core_out = 10'h2A5; core_oe = 2'b10;
        last_pre = '0;
        step(); step();
        chk("R7 reset pins", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
        chk("R7 reset so", {31'd0, so}, 32'd0);
        trst_n = 1'b1;
        step();

        // Sweep: sample+preload, update, extest, leave.
        for (int p = 0; p < 8; p++) begin
            pin_in   = 4'((p * 5 + 3) & 15);
            core_out = 10'((p * 397 + 121) & 1023);
            core_oe  = 2'(p & 3);
            pre      = 16'(p * 40503) ^ 16'h5A5A;
            cv       = cap_vec(pin_in, core_out, core_oe);
            scan(pre, seen, bad);
            chk("R1 R2 R3 captured stream", {16'd0, seen}, {16'd0, cv});
            chk("R5 pins follow core during scan", bad, 0);
            chk("R5 pins follow core after update", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
            extest = 1'b1;
            #1;
            chk("R6 no switch before edge", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
            step();
            chk("R6 extest drives preload", {20'd0, pin_oe, pin_out}, {20'd0, ext_vec(pre)});
            core_out = ~core_out; core_oe = ~core_oe;
            step();
            chk("R6 core ignored in extest", {20'd0, pin_oe, pin_out}, {20'd0, ext_vec(pre)});
            extest = 1'b0;
            step();
            chk("R7 leave extest", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
            last_pre = pre;
        end

        // R8: deselected strobes have no effect.
        extest = 1'b1; step();
        sel = 1'b0; cap = 1'b1; step();
        cap = 1'b0; shf = 1'b1;
        for (int j = 0; j < 4; j++) begin tdi = ~tdi; step(); end
        shf = 1'b0; upd = 1'b1; step();
        upd = 1'b0; step();
        chk("R8 so unchanged", {31'd0, so}, {31'd0, last_pre[15]});
        chk("R8 latches unchanged", {20'd0, pin_oe, pin_out}, {20'd0, ext_vec(last_pre)});

        // R4: latches survive instruction change and test-logic-reset.
        extest = 1'b0; step();
        chk("R7 func again", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
        extest = 1'b1; step();
        chk("R4 latches kept over mode change", {20'd0, pin_oe, pin_out}, {20'd0, ext_vec(last_pre)});
        tlr = 1'b1; step();
        chk("R7 tlr forces func", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
        tlr = 1'b0; step();
        chk("R4 latches kept over tlr", {20'd0, pin_oe, pin_out}, {20'd0, ext_vec(last_pre)});

        // R7: asynchronous reset.
        trst_n = 1'b0; #1;
        chk("R7 async reset pins", {20'd0, pin_oe, pin_out}, {20'd0, core_oe, core_out});
        chk("R7 async reset so", {31'd0, so}, 32'd0);
        step();
        trst_n = 1'b1; extest = 1'b0; step();

        // R3: capture wins over shift.
        pin_in = 4'h6; core_out = 10'h1F0; core_oe = 2'b01;
        cv = cap_vec(pin_in, core_out, core_oe);
        sel = 1'b1; cap = 1'b1; shf = 1'b1; tdi = ~cv[15]; step();
        cap = 1'b0; shf = 1'b0;
        chk("R3 capture priority", {31'd0, so}, {31'd0, cv[15]});
        shf = 1'b1; tdi = 1'b0; step();
        chk("R3 single shift", {31'd0, so}, {31'd0, cv[14]});
        shf = 1'b0; sel = 1'b0; step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule